// File: doc/BRIEF.md
# DDR Address Bit Remapper

This block converts a flat 32-bit physical address into the coordinates a DDR memory uses: a bank number, a row number, a column number and a byte lane inside the word. Before the address is cut into fields, it passes through a bit permutation that software can program. Each bit position of the permuted word takes its value from one selected bit of the incoming address. Software can therefore move the bank bits down so that they sit directly above the column bits. Sequential traffic then steps through banks before it steps through rows, and more banks can be opened in parallel.

The permutation is held in five 32-bit configuration words. Each word carries six 5-bit source indices, and software writes the words through a simple one-cycle write port. After reset the table is the identity mapping. Each request is presented with a valid strobe. One cycle later the decoded fields appear, with their own valid strobe and an error flag for addresses outside the 1 GiB window.

Top module: `ddr_addr_remap`

## Requirements
- R1: After reset the source table is the identity. Address 0x00000000 decodes to bank 0, row 0, column 0, byte 0. Address 0x1CE1CEBB decodes to bank 3, row 19996, column 942, byte 3.
- R2: The 30-bit permuted word is split by position. Byte is bits [1:0], column is bits [11:2], row is bits [26:12] and bank is bits [29:27].
- R3: Bits [5j+4:5j] of configuration word k (j = 0..5) are the index of the address bit that drives permuted position 6k+j. Bits [31:30] of a configuration word have no effect.
- R4: A configuration write whose select is 5, 6 or 7 changes no mapping.
- R5: out_valid rises exactly one cycle after req_valid. In cycles without a request, out_valid is 0 and the field outputs keep their last values.
- R6: out_err is 1 together with out_valid when bit 31 or bit 30 of the request address is set, and 0 otherwise. While out_err is 1 the fields carry no meaning.
- R7: A request in the same cycle as a configuration write is decoded with the old table. The first request after that cycle uses the new table.
- R8: With the bank sourced from address bits [14:12] and the row from address bits [29:15], an address built in that layout decodes back to the bank, row, column and byte it was built from.
- R9: Duplicate source indices are accepted without a check. One address bit then drives every position that names it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Physical address of the request |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Configuration word select (0..4 valid) |
| cfg_wr_data | input | 32 | Configuration word value |
| out_valid | output | 1 | Decoded result valid |
| out_bank | output | 3 | Decoded bank |
| out_row | output | 15 | Decoded row |
| out_col | output | 10 | Decoded column |
| out_byte | output | 2 | Decoded byte lane |
| out_err | output | 1 | Address above the 1 GiB window |

## Verification
A table write and a request can land in the same clock edge. In that case the request must see the table as it was before the write. The bench provokes this by raising cfg_wr_en and req_valid in one cycle with a mapping that changes the result. It expects the old decoding on the first output, then sends the same address again and expects the new decoding. It also sends a request with an out-of-range address while a write is in progress, to show that the range flag does not depend on the table.

// File: rtl/ddr_remap_pkg.sv
package ddr_remap_pkg;
  localparam int ADDR_W  = 32;
  localparam int BYTE_W  = 2;
  localparam int COL_W   = 10;
  localparam int ROW_W   = 15;
  localparam int BANK_W  = 3;
  localparam int USED_W  = BYTE_W + COL_W + ROW_W + BANK_W;
  localparam int IDX_W   = $clog2(ADDR_W);
  localparam int PER_REG = 6;
  localparam int NUM_REGS = (USED_W + PER_REG - 1) / PER_REG;
  localparam int SEL_W   = $clog2(NUM_REGS);
  localparam int FLD_BITS = PER_REG * IDX_W;
  localparam int COL_LSB  = BYTE_W;
  localparam int ROW_LSB  = COL_LSB + COL_W;
  localparam int BANK_LSB = ROW_LSB + ROW_W;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [BYTE_W-1:0] lane;
  } ddr_loc_t;

  // identity indices for configuration word k
  function automatic logic [FLD_BITS-1:0] ident_word(int k);
    logic [FLD_BITS-1:0] w;
    w = '0;
    for (int j = 0; j < PER_REG; j++) begin
      w[j*IDX_W +: IDX_W] = IDX_W'(k*PER_REG + j);
    end
    return w;
  endfunction

  // one address bit chosen by a source index
  function automatic logic pick_bit(logic [ADDR_W-1:0] a, logic [IDX_W-1:0] idx);
    return a[idx];
  endfunction

  // decode a permuted word into its fields
  function automatic ddr_loc_t split_word(logic [USED_W-1:0] p);
    ddr_loc_t l;
    l.lane = p[BYTE_W-1:0];
    l.col  = p[COL_LSB +: COL_W];
    l.row  = p[ROW_LSB +: ROW_W];
    l.bank = p[BANK_LSB +: BANK_W];
    return l;
  endfunction
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import ddr_remap_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [ADDR_W-1:0]       wr_data,
  output logic [USED_W*IDX_W-1:0] src_tbl
);
  logic [NUM_REGS-1:0][FLD_BITS-1:0] cfg_q;
  logic wr_hit;

  assign wr_hit = wr_en && (int'(wr_sel) < NUM_REGS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) cfg_q[k] <= ident_word(k);
    end else if (wr_hit) begin
      cfg_q[wr_sel] <= wr_data[FLD_BITS-1:0];
    end
  end

  assign src_tbl = cfg_q[USED_W*IDX_W/FLD_BITS-1:0];

  genvar gk;
  generate
    for (gk = 0; gk < NUM_REGS; gk++) begin : g_wchk
      // R3
      cfg_word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_sel) == gk) |=> cfg_q[gk] == $past(wr_data[FLD_BITS-1:0]));
    end
  endgenerate

  // R4
  cfg_ignored_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_sel) >= NUM_REGS) |=> $stable(cfg_q));

  // R7
  cfg_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/remap_permute.sv
module remap_permute
  import ddr_remap_pkg::*;
(
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic [USED_W*IDX_W-1:0] src_tbl,
  output logic [USED_W-1:0]       perm
);
  genvar gp;
  generate
    for (gp = 0; gp < USED_W; gp++) begin : g_pos
      assign perm[gp] = pick_bit(addr_in, src_tbl[gp*IDX_W +: IDX_W]);
    end
  endgenerate
endmodule

// File: rtl/remap_field_split.sv
module remap_field_split
  import ddr_remap_pkg::*;
(
  input  logic [USED_W-1:0] perm,
  output ddr_loc_t          loc
);
  assign loc = split_word(perm);
endmodule

// File: rtl/ddr_addr_remap.sv
module ddr_addr_remap
  import ddr_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              cfg_wr_en,
  input  logic [2:0]        cfg_wr_sel,
  input  logic [31:0]       cfg_wr_data,
  output logic              out_valid,
  output logic [2:0]        out_bank,
  output logic [14:0]       out_row,
  output logic [9:0]        out_col,
  output logic [1:0]        out_byte,
  output logic              out_err
);
  logic [USED_W*IDX_W-1:0] src_tbl_w;
  logic [USED_W-1:0]       perm_w;
  ddr_loc_t                loc_w;
  ddr_loc_t                loc_q;
  logic                    range_err_w;
  logic                    valid_q;
  logic                    err_q;

  remap_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (cfg_wr_data),
    .src_tbl (src_tbl_w)
  );

  remap_permute u_perm (
    .addr_in (req_addr),
    .src_tbl (src_tbl_w),
    .perm    (perm_w)
  );

  remap_field_split u_split (
    .perm (perm_w),
    .loc  (loc_w)
  );

  assign range_err_w = |req_addr[ADDR_W-1:USED_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      loc_q   <= '0;
    end else begin
      valid_q <= req_valid;
      err_q   <= req_valid && range_err_w;
      if (req_valid) loc_q <= loc_w;
    end
  end

  assign out_valid = valid_q;
  assign out_err   = err_q;
  assign out_bank  = loc_q.bank;
  assign out_row   = loc_q.row;
  assign out_col   = loc_q.col;
  assign out_byte  = loc_q.lane;

  // R5
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R5
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(loc_q)));
  // R6
  range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:30] != 2'b00) |=> out_err);
  // R6
  err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:30] == 2'b00) |=> !out_err);
endmodule

// File: tb/test_ddr_addr_remap.sv
`timescale 1ns/1ps
module test_ddr_addr_remap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic cfg_wr_en = 1'b0;
  logic [2:0] cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic out_valid, out_err;
  logic [2:0] out_bank;
  logic [14:0] out_row;
  logic [9:0] out_col;
  logic [1:0] out_byte;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int src [30];

  always #2 clk = ~clk;

  ddr_addr_remap i_ddr_addr_remap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .out_valid(out_valid), .out_bank(out_bank), .out_row(out_row),
    .out_col(out_col), .out_byte(out_byte), .out_err(out_err)
  );

  task automatic chk(string tag, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // build a configuration word from the bench's own index list
  function automatic logic [31:0] pack_word(int k, logic [1:0] top);
    logic [31:0] w = {top, 30'd0};
    for (int j = 0; j < 6; j++) w[j*5 +: 5] = 5'(src[k*6+j]);
    return w;
  endfunction

  // expected fields: gather bits per source list, then cut by position
  function automatic logic [29:0] model_word(logic [31:0] a);
    logic [29:0] w;
    for (int p = 0; p < 30; p++) w[p] = a[src[p]];
    return w;
  endfunction

  task automatic set_identity();
    for (int p = 0; p < 30; p++) src[p] = p;
  endtask

  task automatic write_all();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cfg_wr_en = 1; cfg_wr_sel = 3'(k); cfg_wr_data = pack_word(k, 2'b00);
    end
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic send(logic [31:0] a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_fields(string tag, logic [31:0] a);
    logic [29:0] w = model_word(a);
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " byte"}, out_byte, w[1:0]);
    chk({tag, " col"},  out_col,  w[11:2]);
    chk({tag, " row"},  out_row,  w[26:12]);
    chk({tag, " bank"}, out_bank, w[29:27]);
  endtask

  task automatic t_reset();
    // R1
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset err", out_err, 0);
    send(32'h0000_0000);
    chk("R1 zero bank", out_bank, 0); chk("R1 zero row", out_row, 0);
    chk("R1 zero col", out_col, 0);   chk("R1 zero byte", out_byte, 0);
    send(32'h1CE1_CEBB);
    chk("R1 ex bank", out_bank, 3); chk("R1 ex row", out_row, 19996);
    chk("R1 ex col", out_col, 942); chk("R1 ex byte", out_byte, 3);
    chk("R1 ex err", out_err, 0);
  endtask

  task automatic t_layout();
    // R2: walking one through the identity mapping
    set_identity();
    for (int b = 0; b < 30; b++) begin
      send(32'h1 << b);
      expect_fields("R2 walk", 32'h1 << b);
    end
    send(32'h2AAA_AAAA);
    expect_fields("R2 alt", 32'h2AAA_AAAA);
  endtask

  task automatic t_format();
    // R3: word 0 field 0 sources bit 29, word 4 field 5 sources bit 0
    set_identity();
    src[0] = 29; src[29] = 0;
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_sel = 0; cfg_wr_data = pack_word(0, 2'b11);
    @(negedge clk);
    cfg_wr_sel = 4; cfg_wr_data = pack_word(4, 2'b10);
    @(negedge clk);
    cfg_wr_en = 0;
    send(32'h2000_0000);
    chk("R3 byte from bit29", out_byte, 1);
    chk("R3 bank empty", out_bank, 0);
    send(32'h0000_0001);
    chk("R3 bank from bit0", out_bank, 4);
    chk("R3 byte empty", out_byte, 0);
    send(32'h1CE1_CEBB);
    expect_fields("R3 mixed", 32'h1CE1_CEBB);
  endtask

  task automatic t_bad_sel();
    // R4: selects 5..7 must not disturb the table
    for (int s = 5; s < 8; s++) begin
      @(negedge clk);
      cfg_wr_en = 1; cfg_wr_sel = 3'(s); cfg_wr_data = 32'h0000_0000;
    end
    @(negedge clk);
    cfg_wr_en = 0;
    send(32'h2000_0000);
    chk("R4 byte kept", out_byte, 1);
    send(32'h1555_5555);
    expect_fields("R4 table kept", 32'h1555_5555);
  endtask

  task automatic t_latency_hold();
    // R5
    logic [29:0] w;
    set_identity(); write_all();
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0ABC_DEF1;
    chk("R5 not yet", out_valid, 0);
    @(negedge clk);
    req_valid = 0; req_addr = 32'h3FFF_FFFF;
    chk("R5 one cycle", out_valid, 1);
    w = model_word(32'h0ABC_DEF1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 idle valid", out_valid, 0);
      chk("R5 hold row", out_row, w[26:12]);
      chk("R5 hold col", out_col, w[11:2]);
    end
  endtask

  task automatic t_error();
    // R6
    send(32'h8000_0000); chk("R6 bit31", out_err, 1); chk("R6 bit31 v", out_valid, 1);
    send(32'h4000_0000); chk("R6 bit30", out_err, 1);
    send(32'hC123_4567); chk("R6 both", out_err, 1);
    send(32'h3FFF_FFFF); chk("R6 top in range", out_err, 0);
    @(negedge clk);
    chk("R6 idle no err", out_err, 0);
  endtask

  task automatic t_same_cycle();
    // R7: write and request together; first decode uses the old table
    logic [31:0] a = 32'h0000_0001;
    set_identity();
    @(negedge clk);
    src[29] = 0;
    cfg_wr_en = 1; cfg_wr_sel = 4; cfg_wr_data = pack_word(4, 2'b00);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    cfg_wr_en = 0; req_valid = 1; req_addr = a;
    chk("R7 old bank", out_bank, 0);
    chk("R7 old byte", out_byte, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R7 new bank", out_bank, 4);
    // range flag while a write is in flight
    @(negedge clk);
    src[29] = 29;
    cfg_wr_en = 1; cfg_wr_sel = 4; cfg_wr_data = pack_word(4, 2'b00);
    req_valid = 1; req_addr = 32'h8000_0000;
    @(negedge clk);
    cfg_wr_en = 0; req_valid = 0;
    chk("R7 err during write", out_err, 1);
  endtask

  task automatic t_swap();
    // R8: bank from addr[14:12], row from addr[29:15]
    logic [31:0] a;
    set_identity();
    for (int i = 0; i < 3; i++)  src[27+i] = 12 + i;
    for (int j = 0; j < 15; j++) src[12+j] = 15 + j;
    write_all();
    a = (32'h1234 << 15) | (32'd5 << 12) | (32'h155 << 2) | 32'd2;
    send(a);
    chk("R8 bank", out_bank, 5); chk("R8 row", out_row, 15'h1234);
    chk("R8 col", out_col, 10'h155); chk("R8 byte", out_byte, 2);
    send(32'h0000_1000);
    chk("R8 step bank", out_bank, 1); chk("R8 step row", out_row, 0);
  endtask

  task automatic t_dup();
    // R9: bit 3 drives both byte positions
    set_identity();
    src[0] = 3; src[1] = 3;
    write_all();
    send(32'h0000_0008);
    chk("R9 dup byte", out_byte, 3);
    chk("R9 dup col", out_col, 2);
    send(32'h0000_0003);
    chk("R9 dup zero", out_byte, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_layout();
    t_format();
    t_bad_sel();
    t_latency_hold();
    t_error();
    t_same_cycle();
    t_swap();
    t_dup();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule